// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Word Codec

This block protects a data word on its way into and out of storage. The encoder side is combinational. It scatters the data bits over a Hamming layout whose parity bits sit at the power-of-two positions. It then adds one extra bit so that the whole stored word has even parity.

The decoder side takes a stored word back. It recomputes the check bits over the same position groups, including the stored parity bits, to form a syndrome. It also takes the parity of the whole word. From these two results the decoder sorts each word into one of four cases: clean, one bit repaired, damaged beyond repair, or only the extra parity bit flipped. It delivers the repaired data through a register stage, together with a valid strobe, a status code and two error flags.

The data width is a parameter, and the number of check bits follows from it. With the default of 8 data bits there are 4 check bits at positions 1, 2, 4 and 8, the Hamming body has 12 positions, and the stored word is 13 bits wide.

Top module: `hsec_codec`

## Requirements
- R1: On both the encoder output and the decoder input, word bit [p-1] carries position p for p = 1..12, and bit [12] carries the overall parity bit. Data bit 7 goes to position 3; bits 6..0 go to positions 5, 6, 7, 9, 10, 11 and 12, in that order.
- R2: Each check position 2^k holds the XOR of every data position whose number has bit k set. As a result, data 8'hC4 encodes to 13'h129C, whose 12-bit body reads 001110010100 from position 1 to position 12.
- R3: The encoder output always has even parity over all 13 bits.
- R4: out_syndrome holds, as a binary number, the XOR of the positions of every flipped bit in 1..12. Examples: no flip gives 0, a flip at position 1 gives 1, a flip at position 5 gives 5.
- R5: With syndrome 0 and even overall parity, out_status is 0, both flags are low, and out_data equals the stored data bits.
- R6: With a syndrome in 1..12 and odd overall parity, the bit at that position is inverted before data extraction. out_status is 1 and out_single is high.
- R7: With a nonzero syndrome and even overall parity, out_status is 2 and out_double is high. out_data carries the received data bits without any correction.
- R8: With syndrome 0 and odd overall parity, only bit [12] is wrong. out_status is 3, out_single is high, and out_data equals the stored data bits.
- R9: A syndrome above 12 together with odd overall parity is reported as uncorrectable: out_status is 2, out_double is high, and out_data is the uncorrected data.
- R10: out_valid rises exactly one clock after in_valid is sampled high and is low one clock after in_valid is sampled low. While out_valid is low, the data, syndrome, status and flags keep their last values.
- R11: A synchronous active-low reset clears out_valid, out_data, out_syndrome, out_status and both flags to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enc_data | input | 8 | Data word to encode |
| enc_word | output | 13 | Encoded word: Hamming body plus overall parity bit |
| in_valid | input | 1 | in_word is present this cycle |
| in_word | input | 13 | Stored word to check and repair |
| out_valid | output | 1 | Registered result strobe |
| out_data | output | 8 | Repaired or passed-through data |
| out_syndrome | output | 4 | Registered syndrome |
| out_status | output | 2 | 0 clean, 1 repaired, 2 uncorrectable, 3 overall bit only |
| out_single | output | 1 | Statuses 1 and 3 |
| out_double | output | 1 | Status 2 |

## Verification
The bench builds the codec with the default data width of 8, which gives 4 check bits and a 13-bit word. At this width the bench can flip every one of the 13 positions on its own, so it covers both the in-range repair and the overall-bit-only case. The 12-position body also leaves syndromes 13 to 15 unused. Triple flips such as positions 1, 4 and 8 therefore reach the out-of-range rule, which a body filling all syndrome values would never expose. Expected results come from the bench's own knowledge of which bits it flipped, not from recomputing the decoder.

// File: rtl/hsec_pkg.sv
package hsec_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN   = 2'd0,
      ST_FIXED   = 2'd1,
      ST_UNCORR  = 2'd2,
      ST_OVERALL = 2'd3
   } hsec_status_e;

   localparam int MAX_POS = 64;

   // smallest check-bit count k with 2^k >= data + k + 1
   function automatic int par_bits(input int dw);
      for (int k = 1; k < 7; k++) begin
         if ((1 << k) >= dw + k + 1) return k;
      end
      return 7;
   endfunction

   function automatic bit is_pow2(input int p);
      return (p & (p - 1)) == 0;
   endfunction

   // position (1-based) that carries data bit idx; MSB takes the lowest free slot
   function automatic int data_pos(input int dw, input int idx);
      int want;
      int seen;
      want = dw - 1 - idx;
      seen = 0;
      for (int p = 1; p <= MAX_POS; p++) begin
         if (!is_pow2(p)) begin
            if (seen == want) return p;
            seen++;
         end
      end
      return 0;
   endfunction

   // positions covered by check bit k; bit p-1 stands for position p
   function automatic logic [MAX_POS-1:0] cover_mask(input int k);
      logic [MAX_POS-1:0] m;
      m = '0;
      for (int p = 1; p <= MAX_POS; p++) begin
         if (((p >> k) & 1) == 1) m[p-1] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/hsec_encoder.sv
module hsec_encoder
   import hsec_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAR_W  = par_bits(DATA_W),
   parameter int CODE_W = DATA_W + PAR_W
) (
   input  logic [DATA_W-1:0] data,
   output logic [CODE_W:0]   word
);

   logic [CODE_W-1:0] raw;
   logic [CODE_W-1:0] body;
   logic [PAR_W-1:0]  pbits;

   always_comb begin
      raw = '0;
      for (int d = 0; d < DATA_W; d++) begin
         raw[data_pos(DATA_W, d)-1] = data[d];
      end
   end

   for (genvar k = 0; k < PAR_W; k++) begin : g_par
      localparam logic [MAX_POS-1:0] FULL = cover_mask(k);
      localparam logic [CODE_W-1:0]  MASK = FULL[CODE_W-1:0];
      assign pbits[k] = ^(raw & MASK);
   end

   always_comb begin
      body = raw;
      for (int k = 0; k < PAR_W; k++) begin
         body[(1 << k)-1] = pbits[k];
      end
   end

   assign word = {^body, body};

endmodule

// File: rtl/hsec_syndrome.sv
module hsec_syndrome
   import hsec_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAR_W  = par_bits(DATA_W),
   parameter int CODE_W = DATA_W + PAR_W
) (
   input  logic [CODE_W:0]  word,
   output logic [PAR_W-1:0] syn,
   output logic             odd
);

   for (genvar k = 0; k < PAR_W; k++) begin : g_chk
      localparam logic [MAX_POS-1:0] FULL = cover_mask(k);
      localparam logic [CODE_W-1:0]  MASK = FULL[CODE_W-1:0];
      assign syn[k] = ^(word[CODE_W-1:0] & MASK);
   end

   assign odd = ^word;

endmodule

// File: rtl/hsec_correct.sv
module hsec_correct
   import hsec_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAR_W  = par_bits(DATA_W),
   parameter int CODE_W = DATA_W + PAR_W
) (
   input  logic [CODE_W:0]   word,
   input  logic [PAR_W-1:0]  syn,
   input  logic              odd,
   output logic [DATA_W-1:0] data,
   output hsec_status_e      status
);

   logic              syn_nz;
   logic              in_range;
   logic [CODE_W-1:0] fixed;

   assign syn_nz   = |syn;
   assign in_range = (32'(syn) <= 32'(CODE_W));

   always_comb begin
      if (!syn_nz && !odd)        status = ST_CLEAN;
      else if (!syn_nz && odd)    status = ST_OVERALL;
      else if (odd && in_range)   status = ST_FIXED;
      else                        status = ST_UNCORR;
   end

   always_comb begin
      fixed = word[CODE_W-1:0];
      if (status == ST_FIXED) begin
         for (int p = 1; p <= CODE_W; p++) begin
            if (32'(syn) == 32'(p)) fixed[p-1] = ~fixed[p-1];
         end
      end
   end

   always_comb begin
      data = '0;
      for (int d = 0; d < DATA_W; d++) begin
         data[d] = fixed[data_pos(DATA_W, d)-1];
      end
   end

endmodule

// File: rtl/hsec_codec.sv
module hsec_codec
   import hsec_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PAR_W  = par_bits(DATA_W),
   parameter int CODE_W = DATA_W + PAR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] enc_data,
   output logic [CODE_W:0]   enc_word,
   input  logic              in_valid,
   input  logic [CODE_W:0]   in_word,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_data,
   output logic [PAR_W-1:0]  out_syndrome,
   output logic [1:0]        out_status,
   output logic              out_single,
   output logic              out_double
);

   if (DATA_W < 2) begin : g_bad_width
      $error("hsec_codec: DATA_W must be at least 2");
   end
   if (CODE_W > MAX_POS) begin : g_bad_span
      $error("hsec_codec: code word exceeds supported position span");
   end
   if ((1 << PAR_W) < CODE_W + 1) begin : g_bad_par
      $error("hsec_codec: PAR_W too small to address every position");
   end

   hsec_encoder #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_enc (
      .data (enc_data),
      .word (enc_word)
   );

   logic [PAR_W-1:0]  syn_c;
   logic              odd_c;
   logic [DATA_W-1:0] data_c;
   hsec_status_e      status_c;

   hsec_syndrome #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_syn (
      .word (in_word),
      .syn  (syn_c),
      .odd  (odd_c)
   );

   hsec_correct #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_cor (
      .word   (in_word),
      .syn    (syn_c),
      .odd    (odd_c),
      .data   (data_c),
      .status (status_c)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_data     <= '0;
         out_syndrome <= '0;
         out_status   <= 2'd0;
         out_single   <= 1'b0;
         out_double   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data     <= data_c;
            out_syndrome <= syn_c;
            out_status   <= status_c;
            out_single   <= (status_c == ST_FIXED) || (status_c == ST_OVERALL);
            out_double   <= (status_c == ST_UNCORR);
         end
      end
   end

endmodule

// File: rtl/hsec_codec_chk.sv
module hsec_codec_chk #(
   parameter int DATA_W = 8,
   parameter int PAR_W  = 4,
   parameter int CODE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic [CODE_W:0]   enc_word,
   input logic              in_valid,
   input logic              out_valid,
   input logic [DATA_W-1:0] out_data,
   input logic [PAR_W-1:0]  out_syndrome,
   input logic [1:0]        out_status,
   input logic              out_single,
   input logic              out_double
);

   p_enc_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (^enc_word) == 1'b0);

   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_valid_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_hold_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data) && $stable(out_status));

   p_clean_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_status == 2'd0) |-> (!out_single && !out_double && out_syndrome == '0));

   p_fixed_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_status == 2'd1) |-> (out_single && !out_double && out_syndrome != '0));

   p_uncorr_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_status == 2'd2) |-> (out_double && !out_single));

   p_overall_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_status == 2'd3) |-> (out_single && out_syndrome == '0));

   p_reset_clear_r11: assert property (@(posedge clk)
      !rst_n |=> (!out_valid && out_status == 2'd0 && !out_single && !out_double));

endmodule

bind hsec_codec hsec_codec_chk #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CODE_W(CODE_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .enc_word     (enc_word),
   .in_valid     (in_valid),
   .out_valid    (out_valid),
   .out_data     (out_data),
   .out_syndrome (out_syndrome),
   .out_status   (out_status),
   .out_single   (out_single),
   .out_double   (out_double)
);

// File: tb/hsec_codec_test.sv
module hsec_codec_test;

   typedef struct packed {
      logic [7:0] data;
      logic [3:0] syn;
      logic [1:0] status;
      logic       single;
      logic       dbl;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  enc_data = 8'h00;
   logic [12:0] enc_word;
   logic        in_valid = 1'b0;
   logic [12:0] in_word = '0;
   logic        out_valid;
   logic [7:0]  out_data;
   logic [3:0]  out_syndrome;
   logic [1:0]  out_status;
   logic        out_single;
   logic        out_double;

   int   n_checks = 0;
   int   n_fail = 0;
   exp_t q[$];
   logic [7:0] last_data = 8'h00;

   always #5 clk = ~clk;

   hsec_codec uut (
      .clk(clk), .rst_n(rst_n), .enc_data(enc_data), .enc_word(enc_word),
      .in_valid(in_valid), .in_word(in_word), .out_valid(out_valid),
      .out_data(out_data), .out_syndrome(out_syndrome), .out_status(out_status),
      .out_single(out_single), .out_double(out_double)
   );

   // R1/R2 reference: explicit position equations, vector bit [p-1] = position p
   function automatic logic [12:0] ref_enc(input logic [7:0] d);
      logic [12:0] w;
      w = '0;
      w[2]  = d[7];  w[4]  = d[6];  w[5]  = d[5];  w[6] = d[4];
      w[8]  = d[3];  w[9]  = d[2];  w[10] = d[1];  w[11] = d[0];
      w[0]  = w[2] ^ w[4] ^ w[6] ^ w[8] ^ w[10];
      w[1]  = w[2] ^ w[5] ^ w[6] ^ w[9] ^ w[10];
      w[3]  = w[4] ^ w[5] ^ w[6] ^ w[11];
      w[7]  = w[8] ^ w[9] ^ w[10] ^ w[11];
      w[12] = ^w[11:0];
      return w;
   endfunction

   function automatic logic [7:0] ref_extract(input logic [12:0] w);
      return {w[2], w[4], w[5], w[6], w[8], w[9], w[10], w[11]};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // driver: flip up to three positions (1..13, 0 = none), push expectation
   task automatic send(input logic [7:0] d, input int f1, input int f2, input int f3, input string req);
      logic [12:0] w;
      exp_t e;
      int nf;
      logic [3:0] sx;
      w = ref_enc(d);
      enc_data = d;
      #1;
      check(enc_word == w, "R2", "encoder word", 32'(enc_word), 32'(w));
      nf = 0;
      sx = 4'd0;
      if (f1 != 0) begin w[f1-1] = ~w[f1-1]; nf++; if (f1 <= 12) sx ^= 4'(f1); end
      if (f2 != 0) begin w[f2-1] = ~w[f2-1]; nf++; if (f2 <= 12) sx ^= 4'(f2); end
      if (f3 != 0) begin w[f3-1] = ~w[f3-1]; nf++; if (f3 <= 12) sx ^= 4'(f3); end
      e.syn = sx;
      if (nf == 0) begin
         e.data = d; e.status = 2'd0; e.single = 1'b0; e.dbl = 1'b0;
      end else if (nf == 1 && f1 == 13) begin
         e.data = d; e.status = 2'd3; e.single = 1'b1; e.dbl = 1'b0;
      end else if (nf == 1) begin
         e.data = d; e.status = 2'd1; e.single = 1'b1; e.dbl = 1'b0;
      end else begin
         e.data = ref_extract(w); e.status = 2'd2; e.single = 1'b0; e.dbl = 1'b1;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_word = w;
      q.push_back(e);
      last_data = e.data;
      if (req != "") $display("  case %s data=%0h flips=%0d,%0d,%0d", req, d, f1, f2, f3);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   // monitor: compare each registered result against the queue head
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (q.size() == 0) begin
            check(1'b0, "R10", "unexpected out_valid", 32'(out_valid), 32'd0);
         end else begin
            exp_t e;
            exp_t a;
            e = q.pop_front();
            a = '{data: out_data, syn: out_syndrome, status: out_status,
                  single: out_single, dbl: out_double};
            check(a == e, "R4-R9 result", "data/syn/status/flags",
                  32'(a), 32'(e));
         end
      end
   end

   logic [7:0] clean_list [6] = '{8'hC4, 8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};

   initial begin : main
      repeat (3) @(negedge clk);
      // R11 reset state
      check(out_valid == 1'b0 && out_data == 8'h00 && out_syndrome == 4'h0 &&
            out_status == 2'd0 && !out_single && !out_double,
            "R11", "reset outputs", {out_valid, out_data, out_status}, 32'd0);
      enc_data = 8'hC4;
      #1;
      check(enc_word == 13'h129C, "R2", "encode C4", 32'(enc_word), 32'h129C);
      check((^enc_word) == 1'b0, "R3", "even parity", 32'(^enc_word), 32'd0);
      check(enc_word[2] == 1'b1 && enc_word[4] == 1'b1 && enc_word[11] == 1'b0,
            "R1", "data placement", 32'(enc_word), 32'h129C);
      @(negedge clk);
      rst_n = 1'b1;

      // R5 clean words
      foreach (clean_list[i]) send(clean_list[i], 0, 0, 0, "R5");
      // R4 examples and R6/R8 single flips at every position
      for (int p = 1; p <= 13; p++) send(8'hC4, p, 0, 0, (p == 13) ? "R8" : "R6");
      idle(2);
      for (int p = 1; p <= 13; p++) send(8'hA5, p, 0, 0, (p == 13) ? "R8" : "R4");
      // R7 double flips
      send(8'h5A, 1, 5, 0, "R7");
      send(8'hFF, 3, 12, 0, "R7");
      send(8'h81, 2, 13, 0, "R7");
      send(8'h3C, 7, 9, 0, "R7");
      // R9 syndrome beyond position 12 with odd parity
      send(8'h00, 1, 4, 8, "R9");
      send(8'hC4, 6, 8, 13, "R9");
      send(8'h96, 0, 0, 0, "R10");
      idle(1);
      @(negedge clk);
      @(negedge clk);
      // R10 hold after valid drops
      check(out_valid == 1'b0, "R10", "valid low when idle", 32'(out_valid), 32'd0);
      check(out_data == last_data, "R10", "data held", 32'(out_data), 32'(last_data));
      check(q.size() == 0, "R10", "all results seen", 32'(q.size()), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin : watchdog
      #(200000 * 10);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

endmodule